// File: doc/BRIEF.md
# Bidirectional HH:MM:SS Tape Counter

This block holds an elapsed-time value as six binary-coded-decimal digits, a pair each for hours, minutes and seconds. On each rising clock edge it can step the value forward or backward by exactly one second. With no step request, the value stays where it is. Carries and borrows ripple through all six digits. The ones digits of seconds and minutes cycle through 0..9, and their tens digits cycle through 0..5. The hours pair runs 00..99 as a plain tally, not as a time of day.

Each digit is a separate 4-bit output, so a later display stage can decode it on its own. Reset is synchronous and active low. Reset returns the value to 00:00:00.

Top module: `tape_time_counter`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, the digits read 00:00:00 after that edge.
- R2: Reset wins over both step inputs: a step request in a reset cycle is ignored and the value still reads 00:00:00.
- R3: With `rst_n` high and `inc_i` high, the value read as seconds (h*3600 + m*60 + s) is one larger after the edge.
- R4: With `rst_n` high, `inc_i` low and `dec_i` high, the value read as seconds is one smaller after the edge.
- R5: With both step inputs low, all six digits keep their values across the edge.
- R6: When `inc_i` and `dec_i` are both high, the counter steps up, never down.
- R7: Stepping up carries correctly: a seconds or minutes ones digit goes from 9 to 0, its tens digit goes from 5 to 0, and each carry moves one digit further. For example, 00:00:59 becomes 00:01:00, and 09:59:59 becomes 10:00:00.
- R8: Stepping down borrows correctly. A ones digit at 0 goes to 9. A seconds or minutes tens digit at 0 goes to 5. For example, 10:00:00 becomes 09:59:59, and 00:01:00 becomes 00:00:59.
- R9: The range wraps at both ends. Stepping up from 99:59:59 gives 00:00:00, and stepping down from 00:00:00 gives 99:59:59.
- R10: Every digit is always a BCD value in the range 0..9. After reset, the tens digits of minutes and seconds never go above 5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| inc_i | input | 1 | Step forward one second (active high) |
| dec_i | input | 1 | Step backward one second (active high) |
| hr_tens | output | 4 | Hours, tens digit (BCD) |
| hr_ones | output | 4 | Hours, ones digit (BCD) |
| min_tens | output | 4 | Minutes, tens digit (BCD, 0..5) |
| min_ones | output | 4 | Minutes, ones digit (BCD) |
| sec_tens | output | 4 | Seconds, tens digit (BCD, 0..5) |
| sec_ones | output | 4 | Seconds, ones digit (BCD) |

## Verification
The hardest condition to reach is a carry into, or a borrow out of, the hours tens digit. That digit moves only when the five digits below it are all at their limit, 36000 steps away from reset going up. The stimulus reaches it with one long run of increments from 00:00:00 through 10:00:00, followed by a few decrements back across that boundary. The random phase mixes up, down, both and idle requests with occasional resets. Near zero, this phase keeps crossing the 00:00:00 / 99:59:59 wrap in both directions.

// File: rtl/tc_pkg.sv
// Package: shared constants and types for the tape time counter.
// Assumes digit index 0 is the seconds ones digit and index 5 the hours tens.
package tc_pkg;

    localparam int DIGIT_W    = 4;
    localparam int NUM_DIGITS = 6;

    // Requested step for the current cycle, already resolved for priority.
    typedef enum logic [1:0] {
        STEP_NONE = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

    // Highest value a digit reaches before it wraps; tens of min/sec stop at 5.
    function automatic int digit_top(input int idx);
        if (idx == 1 || idx == 3) begin
            return 5;
        end
        return 9;
    endfunction

endpackage

// File: rtl/tc_step_ctrl.sv
// Module: tc_step_ctrl
// Turns the raw increment/decrement requests into one step command.
// Assumes the inputs are already synchronous to the counter clock.
// Increment wins when both requests are high.
module tc_step_ctrl
    import tc_pkg::*;
(
    input  logic  inc_i,
    input  logic  dec_i,
    output step_e step_o
);

    // Resolve the two requests into a single command with up-priority.
    always_comb begin
        if (inc_i) begin
            step_o = STEP_UP;
        end else if (dec_i) begin
            step_o = STEP_DOWN;
        end else begin
            step_o = STEP_NONE;
        end
    end

endmodule

// File: rtl/tc_digit_cell.sv
// Module: tc_digit_cell
// One decimal digit of the counter.
// Counts 0..TOP up or down when the lower digits pass it a ripple enable.
// Assumes every lower digit sits at its limit whenever ripple_i is high
// (the top level builds this chain).
module tc_digit_cell
    import tc_pkg::*;
#(
    parameter int WIDTH = DIGIT_W,
    parameter int TOP   = 9
) (
    input  logic             clk,
    input  logic             rst_n,
    input  step_e            step_i,
    input  logic             ripple_i,
    output logic [WIDTH-1:0] digit_o,
    output logic             ripple_o
);

    localparam logic [WIDTH-1:0] TOP_V  = WIDTH'(TOP);
    localparam logic [WIDTH-1:0] ZERO_V = '0;

    logic [WIDTH-1:0] digit_q;
    logic             at_limit;

    // Decide whether this digit wraps on the current step direction.
    always_comb begin
        unique case (step_i)
            STEP_UP:   at_limit = (digit_q == TOP_V);
            STEP_DOWN: at_limit = (digit_q == ZERO_V);
            default:   at_limit = 1'b0;
        endcase
    end

    // Digit register: synchronous clear, then wrap or step by one.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= ZERO_V;
        end else if (ripple_i && step_i == STEP_UP) begin
            digit_q <= at_limit ? ZERO_V : digit_q + WIDTH'(1);
        end else if (ripple_i && step_i == STEP_DOWN) begin
            digit_q <= at_limit ? TOP_V : digit_q - WIDTH'(1);
        end
    end

    assign ripple_o = ripple_i & at_limit;
    assign digit_o  = digit_q;

endmodule

// File: rtl/tape_time_counter.sv
// Module: tape_time_counter
// A six-digit BCD HH:MM:SS up/down counter whose hours run 00..99.
// One step control feeds a chain of digit cells.
// The ripple enable goes from the seconds ones digit up to the hours tens digit.
// Assumes the step inputs are synchronous; reset is synchronous, active low.
module tape_time_counter
    import tc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       inc_i,
    input  logic       dec_i,
    output logic [3:0] hr_tens,
    output logic [3:0] hr_ones,
    output logic [3:0] min_tens,
    output logic [3:0] min_ones,
    output logic [3:0] sec_tens,
    output logic [3:0] sec_ones
);

    step_e                step;
    logic [NUM_DIGITS:0]  ripple;
    logic [DIGIT_W-1:0]   digits [NUM_DIGITS];

    tc_step_ctrl u_step (
        .inc_i  (inc_i),
        .dec_i  (dec_i),
        .step_o (step)
    );

    // Any step request enables the lowest digit.
    assign ripple[0] = (step != STEP_NONE);

    generate
        for (genvar gi = 0; gi < NUM_DIGITS; gi++) begin : g_digit
            tc_digit_cell #(
                .WIDTH (DIGIT_W),
                .TOP   (digit_top(gi))
            ) u_cell (
                .clk      (clk),
                .rst_n    (rst_n),
                .step_i   (step),
                .ripple_i (ripple[gi]),
                .digit_o  (digits[gi]),
                .ripple_o (ripple[gi+1])
            );
        end
    endgenerate

    assign sec_ones = digits[0];
    assign sec_tens = digits[1];
    assign min_ones = digits[2];
    assign min_tens = digits[3];
    assign hr_ones  = digits[4];
    assign hr_tens  = digits[5];

endmodule

// File: rtl/tc_checker.sv
// Module: tc_checker
// Port-level properties for tape_time_counter.
// Bound to the top module; it reads the counter ports only.
module tc_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       inc_i,
    input logic       dec_i,
    input logic [3:0] hr_tens,
    input logic [3:0] hr_ones,
    input logic [3:0] min_tens,
    input logic [3:0] min_ones,
    input logic [3:0] sec_tens,
    input logic [3:0] sec_ones
);

    localparam int SPAN = 360000;

    int tot;

    // Express the six digits as a single seconds count.
    always_comb begin
        tot = (int'(hr_tens) * 10 + int'(hr_ones)) * 3600
            + (int'(min_tens) * 10 + int'(min_ones)) * 60
            + int'(sec_tens) * 10 + int'(sec_ones);
    end

    AST_RESET_CLEARS: assert property (@(posedge clk)
        !rst_n |=> tot == 0);                                    // R1
    AST_RESET_WINS: assert property (@(posedge clk)
        (!rst_n && (inc_i || dec_i)) |=> tot == 0);              // R2
    AST_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && !dec_i) |=> tot == ($past(tot) + 1) % SPAN);   // R3
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && dec_i) |=> tot == ($past(tot) + SPAN - 1) % SPAN); // R4
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && !dec_i) |=> $stable(tot));                    // R5
    AST_BOTH_GOES_UP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && dec_i) |=> tot == ($past(tot) + 1) % SPAN);    // R6
    AST_SEC_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && sec_tens == 4'd5 && sec_ones == 4'd9)
        |=> (sec_tens == 4'd0 && sec_ones == 4'd0));             // R7
    AST_SEC_BORROW: assert property (@(posedge clk) disable iff (!rst_n)
        (!inc_i && dec_i && sec_tens == 4'd0 && sec_ones == 4'd0)
        |=> (sec_tens == 4'd5 && sec_ones == 4'd9));             // R8
    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (inc_i && tot == SPAN - 1) |=> tot == 0);                // R9
    AST_BCD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (hr_tens <= 4'd9 && hr_ones <= 4'd9 && min_tens <= 4'd5 &&
         min_ones <= 4'd9 && sec_tens <= 4'd5 && sec_ones <= 4'd9)); // R10

endmodule

bind tape_time_counter tc_checker u_tc_checker (.*);

// File: tb/tb_tape_time_counter.sv
// Bench for tape_time_counter.
// A seconds-count reference model is checked after every edge.
// Random stimulus uses a fixed seed; directed runs cover the wrap and hours carries.
module tb_tape_time_counter;

    localparam int SPAN = 360000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       inc_i = 1'b0;
    logic       dec_i = 1'b0;
    logic [3:0] hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones;

    int n_checks = 0;
    int n_fail   = 0;
    int model    = 0;

    always #4 clk = ~clk;

    tape_time_counter dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .inc_i    (inc_i),
        .dec_i    (dec_i),
        .hr_tens  (hr_tens),
        .hr_ones  (hr_ones),
        .min_tens (min_tens),
        .min_ones (min_ones),
        .sec_tens (sec_tens),
        .sec_ones (sec_ones)
    );

    // Expected six digits (hours tens first) for a seconds count.
    function automatic logic [23:0] to_digits(input int t);
        int h, m, s;
        h = t / 3600;
        m = (t / 60) % 60;
        s = t % 60;
        return {4'(h / 10), 4'(h % 10), 4'(m / 10), 4'(m % 10),
                4'(s / 10), 4'(s % 10)};
    endfunction

    // Apply one cycle of inputs, advance the model, and compare after the edge.
    task automatic cycle(input logic r, input logic up, input logic dn);
        int          prev;
        string       tag;
        logic [23:0] got, exp;
        @(negedge clk);
        rst_n = r;
        inc_i = up;
        dec_i = dn;
        @(posedge clk);
        prev = model;
        if (!r) begin
            model = 0;
            tag = (up || dn) ? "R2" : "R1";
        end else if (up) begin
            model = (model + 1) % SPAN;
            tag = dn ? "R6" : "R3";
            if (prev == SPAN - 1) tag = "R9";
            else if (model % 60 == 0) tag = "R7";
        end else if (dn) begin
            model = (model + SPAN - 1) % SPAN;
            tag = "R4";
            if (prev == 0) tag = "R9";
            else if (prev % 60 == 0) tag = "R8";
        end else begin
            tag = "R5";
        end
        #1;
        got = {hr_tens, hr_ones, min_tens, min_ones, sec_tens, sec_ones};
        exp = to_digits(model);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: digits actual %h expected %h", tag, got, exp);
        end
        n_checks++;
        if (!(hr_tens <= 9 && hr_ones <= 9 && min_tens <= 5 && min_ones <= 9 &&
              sec_tens <= 5 && sec_ones <= 9)) begin
            n_fail++;
            $display("FAIL R10: digits actual %h expected BCD within limits", got);
        end
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240607));
        // R1: reset state
        cycle(1'b0, 1'b0, 1'b0);
        cycle(1'b0, 1'b0, 1'b0);
        // R2: reset beats step requests
        cycle(1'b0, 1'b1, 1'b0);
        cycle(1'b0, 1'b1, 1'b1);
        // R9: down-wrap from zero, then back up through the top
        cycle(1'b1, 1'b0, 1'b1);
        cycle(1'b1, 1'b1, 1'b0);
        // R5 and R6 directed
        cycle(1'b1, 1'b0, 1'b0);
        cycle(1'b1, 1'b1, 1'b1);
        // Constrained random mix around zero
        for (int i = 0; i < 3000; i++) begin
            logic [4:0] rr;
            rr = 5'($urandom);
            cycle(rr != 5'd0, 1'($urandom), 1'($urandom));
        end
        // Long up-run from reset through 10:00:00 (R7 hours-tens carry)
        cycle(1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 36002; i++) begin
            cycle(1'b1, 1'b1, 1'b0);
        end
        // Borrow back across 10:00:00 (R8)
        for (int i = 0; i < 4; i++) begin
            cycle(1'b1, 1'b0, 1'b1);
        end
        cycle(1'b1, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule